// File: doc/BRIEF.md
# Restoring Division Step Engine

The block runs one conditional-subtract division step per clock on a 36-bit accumulator. The accumulator is made of a 4-bit extension, a 16-bit high part and a 16-bit low part. In each step the 16-bit divisor is placed so that its least significant bit sits at accumulator bit 15, and it is subtracted from the accumulator. If the 36-bit difference is negative, the old accumulator is shifted left by one and a 0 enters at bit 0. Otherwise the difference is shifted left by one and a 1 enters at bit 0.

A sequencer repeats the step a programmed number of times, n+1 for an 8-bit count n. The run cannot be interrupted. Software preloads the accumulator with the dividend, then pulses start with the divisor and the count. For a positive 16-bit dividend in the low part, 16 steps leave the quotient in the low part and the remainder in the high part. Sign correction before and after the run is left to the surrounding logic.

The sequencer has three states. In `ST_IDLE` the block accepts loads and starts. `ST_RUN` performs one step per cycle. `ST_DONE` raises the done pulse for one cycle. The transitions are:
- IDLE→RUN when start is sampled.
- RUN→RUN while the remaining count is non-zero.
- RUN→DONE on the step that finds the remaining count at zero.
- DONE→IDLE unconditionally.

Top module: `divstep_engine`

## Requirements
- R1: After reset the accumulator reads 0, done_o is 0 and zero_o is 0.
- R2: In the idle state, load_i (without start_i) writes load_val_i into the accumulator, visible on acc_o in the next cycle. zero_o is not changed by a load.
- R3: Each step forms the 36-bit difference t = acc − (divisor << 15). t is treated as negative exactly when its bit 35 is 1, so a difference of exactly zero counts as non-negative.
- R4: When t is negative, the new accumulator is the old accumulator shifted left by one with bit 0 cleared.
- R5: When t is non-negative, the new accumulator is t shifted left by one with bit 0 set.
- R6: A start with count_i = n performs exactly n+1 steps, from 1 step (n = 0) to 256 steps (n = 255). The steps run one per cycle, and the first step happens on the edge after the one that samples start.
- R7: done_o is 1 for exactly one cycle, the cycle after the final step. acc_o then holds the final result and keeps it while idle.
- R8: While a run is in progress (the run and done states), start_i and load_i are ignored. They neither restart the count nor alter the accumulator.
- R9: After every step zero_o equals 1 when the new accumulator is all zeros and 0 otherwise. Between steps zero_o holds its value.
- R10: With a dividend below 2^15 in the low part (upper bits zero), a divisor from 1 to 0x7FFF and n = 15, the final low part is the quotient and the high part (bits 31:16) is the remainder.
- R11: If start_i and load_i are both high in the idle state, start wins and the load is dropped.
- R12: The divisor and the count are captured when start is sampled. Later changes on divisor_i and count_i have no effect on the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run (sampled only when idle) |
| load_i | input | 1 | Write load_val_i into the accumulator when idle |
| load_val_i | input | 36 | Dividend / accumulator load value |
| divisor_i | input | 16 | Divisor, captured at start |
| count_i | input | 8 | Repeat count n; run performs n+1 steps |
| acc_o | output | 36 | Accumulator |
| done_o | output | 1 | One-cycle pulse after the final step |
| zero_o | output | 1 | Accumulator was zero after the latest step |

## Verification
The assertions assume that reset is held low for at least one clock before the first run. They also assume that start_i and load_i are plain levels sampled on the rising edge. The bench keeps to this by changing every input on the falling edge. It also deliberately raises start_i and load_i, and scrambles divisor_i and count_i, while a run is in progress, because that is when the block must ignore them. The quotient and remainder checks use only dividends below 2^15 and divisors from 1 to 0x7FFF, the range in which that result holds. The other runs use arbitrary accumulator values and are compared against a step-by-step model written from R3 to R5.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/divstep_alu.sv
module divstep_alu #(
    parameter int ACC_W = 36,
    parameter int DIV_W = 16,
    parameter int ALIGN = 15
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [ACC_W-1:0] next_o,
    output logic             neg_o
);
    localparam int PAD = ACC_W - DIV_W - ALIGN;

    logic [ACC_W-1:0] scaled;
    logic [ACC_W-1:0] diff;

    generate
        if (ALIGN == 0) begin : g_no_align
            assign scaled = {{PAD{1'b0}}, div_i};
        end else begin : g_align
            assign scaled = {{PAD{1'b0}}, div_i, {ALIGN{1'b0}}};
        end
    endgenerate

    always_comb begin
        diff  = acc_i - scaled;
        neg_o = diff[ACC_W-1];
        if (neg_o) begin
            next_o = {acc_i[ACC_W-2:0], 1'b0};
        end else begin
            next_o = {diff[ACC_W-2:0], 1'b1};
        end
    end

endmodule

// File: rtl/divstep_seq.sv
module divstep_seq
    import divstep_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             step_o,
    output logic             done_o,
    output logic             idle_o
);
    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (rem_q == '0) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            rem_q <= count_i;
        end else if (state_q == ST_RUN && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    always_comb begin
        step_o = 1'b0;
        done_o = 1'b0;
        idle_o = 1'b0;
        unique case (state_q)
            ST_IDLE: idle_o = 1'b1;
            ST_RUN:  step_o = 1'b1;
            ST_DONE: done_o = 1'b1;
            default: idle_o = 1'b1;
        endcase
    end

    // R7: done is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: the step taken with the count exhausted is followed by done
    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && rem_q == '0) |=> done_o);

    // R6 / R8: the count falls by one per step, whatever start_i does
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && rem_q != '0) |=>
            (state_q == ST_RUN && rem_q == CNT_W'($past(rem_q) - 1'b1)));

    // R8: start during done does not begin a new run
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && start_i) |=> idle_o);

endmodule

// File: rtl/divstep_engine.sv
module divstep_engine
    import divstep_pkg::*;
#(
    parameter int ACC_W = 36,
    parameter int DIV_W = 16,
    parameter int ALIGN = 15,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             load_i,
    input  logic [ACC_W-1:0] load_val_i,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             done_o,
    output logic             zero_o
);
    logic [ACC_W-1:0] acc_q;
    logic [DIV_W-1:0] div_q;
    logic             zero_q;
    logic             step_w;
    logic             idle_w;
    logic             done_w;
    logic [ACC_W-1:0] alu_next;
    logic             alu_neg;
    logic             take_load;
    logic             take_start;

    divstep_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .count_i (count_i),
        .step_o  (step_w),
        .done_o  (done_w),
        .idle_o  (idle_w)
    );

    divstep_alu #(.ACC_W(ACC_W), .DIV_W(DIV_W), .ALIGN(ALIGN)) u_alu (
        .acc_i  (acc_q),
        .div_i  (div_q),
        .next_o (alu_next),
        .neg_o  (alu_neg)
    );

    assign take_start = idle_w & start_i;
    assign take_load  = idle_w & load_i & ~start_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (take_start) begin
            div_q <= divisor_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            zero_q <= 1'b0;
        end else if (step_w) begin
            acc_q  <= alu_next;
            zero_q <= (alu_next == '0);
        end else if (take_load) begin
            acc_q <= load_val_i;
        end
    end

    assign acc_o  = acc_q;
    assign done_o = done_w;
    assign zero_o = zero_q;

    // R2: an idle load shows up on the next cycle
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_load |=> acc_o == $past(load_val_i));

    // R4: a negative difference enters a 0 quotient bit
    p_qbit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_w && alu_neg) |=> !acc_o[0]);

    // R5: a non-negative difference enters a 1 quotient bit
    p_qbit_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_w && !alu_neg) |=> acc_o[0]);

    // R9: zero flag tracks the stepped accumulator
    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        step_w |=> zero_o == (acc_o == '0));

    // R9: zero flag holds when no step is taken
    p_zero_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_w |=> $stable(zero_o));

    // R8: a load in the done state leaves the accumulator alone
    p_busy_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_w && load_i) |=> $stable(acc_o));

endmodule

// File: tb/divstep_engine_bench.sv
module divstep_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        load_i = 1'b0;
    logic [35:0] load_val_i = '0;
    logic [15:0] divisor_i = '0;
    logic [7:0]  count_i = '0;
    logic [35:0] acc_o;
    logic        done_o;
    logic        zero_o;

    int n_checks = 0;
    int n_fail = 0;
    logic [36:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    divstep_engine u_divstep_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_i(load_i),
        .load_val_i(load_val_i), .divisor_i(divisor_i), .count_i(count_i),
        .acc_o(acc_o), .done_o(done_o), .zero_o(zero_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Step model from R3 to R5: returns {zero, acc}
    function automatic logic [36:0] model(input logic [35:0] a, input logic [15:0] d,
                                          input int n);
        logic [35:0] t;
        for (int k = 0; k <= n; k++) begin
            t = a - ({20'd0, d} << 15);
            if (t[35]) a = {a[34:0], 1'b0};
            else       a = {t[34:0], 1'b1};
        end
        return {(a == 36'd0), a};
    endfunction

    // Monitor: compares each finished run against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected done", 64'd1, 64'd0);
            end else begin
                logic [36:0] e;
                string tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(acc_o == e[35:0], {tg, " acc"}, 64'(acc_o), 64'(e[35:0]));
                chk(zero_o == e[36], {"R9 ", tg, " zero"}, 64'(zero_o), 64'(e[36]));
            end
        end
    end

    // Waits out a run whose start was sampled just before the current negedge
    task automatic wait_run(input int n, input bit poke);
        if (poke) begin
            start_i = 1'b1; load_i = 1'b1; load_val_i = 36'hF_FFFF_FFFF;
        end
        for (int i = 1; i <= n + 1; i++) begin
            @(negedge clk);
            start_i = 1'b0; load_i = 1'b0;
            if (i <= n) chk(done_o == 1'b0, "R6 early done", 64'(done_o), 64'd0);
        end
        chk(done_o == 1'b1, "R6/R7 done after n+1 steps", 64'(done_o), 64'd1);
        @(negedge clk);
        chk(done_o == 1'b0, "R7 done one cycle", 64'(done_o), 64'd0);
    endtask

    task automatic run_case(input logic [35:0] a, input logic [15:0] d, input int n,
                            input string tag, input bit poke);
        @(negedge clk);
        load_i = 1'b1; load_val_i = a;
        @(negedge clk);
        load_i = 1'b0;
        chk(acc_o == a, "R2 load", 64'(acc_o), 64'(a));
        start_i = 1'b1; divisor_i = d; count_i = 8'(n);
        exp_q.push_back(model(a, d, n));
        tag_q.push_back(tag);
        @(negedge clk);
        start_i = 1'b0; divisor_i = ~d; count_i = ~8'(n);   // R12 scramble
        wait_run(n, poke);
    endtask

    task automatic quot_case(input logic [15:0] a, input logic [15:0] d);
        run_case({20'd0, a}, d, 15, "R10", 1'b0);
        chk(acc_o[15:0] == a / d, "R10 quotient", 64'(acc_o[15:0]), 64'(a / d));
        chk(acc_o[31:16] == a % d, "R10 remainder", 64'(acc_o[31:16]), 64'(a % d));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc_o == 36'd0, "R1 acc", 64'(acc_o), 64'd0);
        chk(done_o == 1'b0, "R1 done", 64'(done_o), 64'd0);
        chk(zero_o == 1'b0, "R1 zero", 64'(zero_o), 64'd0);

        quot_case(16'd100, 16'd7);
        quot_case(16'h7FFF, 16'd1);
        quot_case(16'd12345, 16'h7FFF);
        // R3/R5: difference exactly zero is non-negative -> result 1
        run_case(36'h0_0002_8000, 16'd5, 0, "R3 R5 exact", 1'b0);
        chk(acc_o == 36'd1, "R3 exact zero difference", 64'(acc_o), 64'd1);
        // R4: negative difference shifts old value
        run_case(36'h0_0002_7FFF, 16'd5, 0, "R4 negative", 1'b0);
        chk(acc_o == 36'h0_0004_FFFE, "R4 shift", 64'(acc_o), 64'h4FFFE);
        // R9: zero result from a single step
        run_case(36'd0, 16'd5, 0, "R9 zero", 1'b0);
        // R9: a load does not alter zero_o
        @(negedge clk);
        load_i = 1'b1; load_val_i = 36'h0_0000_1234;
        @(negedge clk);
        load_i = 1'b0;
        chk(zero_o == 1'b1, "R9 zero held over load", 64'(zero_o), 64'd1);
        // R8 with pokes, R6 at maximum count
        run_case(36'h0_0001_F000, 16'd3, 3, "R8 poke", 1'b1);
        run_case(36'h9_1234_5678, 16'hABCD, 255, "R6 max count", 1'b1);
        // R11: start and load together -> start wins
        @(negedge clk);
        load_i = 1'b1; load_val_i = 36'h0_0000_0064;
        @(negedge clk);
        load_val_i = 36'h5_5555_5555; start_i = 1'b1;
        divisor_i = 16'd7; count_i = 8'd15;
        exp_q.push_back(model(36'h0_0000_0064, 16'd7, 15));
        tag_q.push_back("R11 start over load");
        @(negedge clk);
        start_i = 1'b0; load_i = 1'b0;
        wait_run(15, 1'b0);
        chk(acc_o == 36'h0_0002_000E, "R11 result", 64'(acc_o), 64'h2000E);
        // Mixed patterns
        for (int r = 0; r < 4; r++) begin
            run_case({$urandom(), 4'($urandom())}, 16'($urandom()),
                     int'($urandom_range(0, 20)), "R3 R4 R5 mixed", 1'(r));
        end
        @(negedge clk);
        chk(exp_q.size() == 0, "R7 all runs completed", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule